// File: doc/BRIEF.md
# Flash Cache Control and Flush Unit

This block is the control side of an execute-in-place flash cache. Software uses a small register bus to program three control bits: cache enable, bad-write error, and power-down. It can also request a flush and read a status word. The block sends the enable and power-down levels to the cache datapath. It drives a clear port into the tag RAM. It also tells the datapath when tag lookups may be used.

Flushing invalidates tags only. A sequencer writes one tag index per clock, in increasing order, and leaves the data RAM untouched. A flush starts by itself when reset is released and again whenever software requests one. While a flush runs, lookups are held off. A read of the flush register is wait-stated until the walk is complete.

For each access that the datapath presents, the block decides the response in the same cycle: a bus error, a silently dropped write, or a line invalidation. The decision depends on the alias the access uses, whether it targets the cache-as-SRAM window, and the current control bits.

Top module: `flash_cache_ctl`

## Requirements
- R1: After reset, the control word reads 0 (enable, bad-write and power-down all clear). A flush starts at once and clears indices 0 to NUM_LINES-1, one per clock. The first index is cleared in the cycle that follows reset release.
- R2: A write to register offset 0 updates the control word. Bit 0 is enable, bit 1 is bad-write error and bit 3 is power-down. A read of offset 0 returns these bits in the same positions, with all other bits 0.
- R3: When a control write sets power-down to 1, enable is stored as 0 whatever bit 0 holds. `cache_en` and `cache_pd` are never both 1.
- R4: A write to offset 1 with bit 0 set, made while no flush is running, starts a flush. `tag_clr_we` is high for exactly NUM_LINES cycles, and `tag_clr_idx` counts 0, 1, …, NUM_LINES-1. A write to offset 1 with bit 0 clear does nothing.
- R5: Bit 0 of the status register (offset 2) and `flush_ready` are 0 while a flush runs. Both are 1 otherwise. `flush_ready` rises in the cycle after index NUM_LINES-1 is cleared.
- R6: A read of offset 1 holds `reg_stall` high for as long as a flush is running. Once the stall is released, the read returns 0.
- R7: A flush request made while a flush is already running is ignored. The walk in progress continues without restarting.
- R8: `lookup_en` is 1 only when enable is 1 and no flush is running.
- R9: A write through any alias other than 0 (0 being the cached, allocating alias) that is not a cache-as-SRAM access behaves as follows. It raises `acc_err` when bad-write is 1. It raises `acc_drop` instead when bad-write is 0.
- R10: A write through alias 0 with `acc_hit` high raises `line_inv` whenever `lookup_en` is 1, whatever the bad-write setting. Such a write never raises `acc_err`.
- R11: A cache-as-SRAM access, read or write, raises `acc_err` when enable or power-down is 1. Otherwise it completes with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access request, held while stalled |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Word offset: 0 control, 1 flush, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_valid is high and reg_stall is low |
| reg_stall | output | 1 | Wait-state for a flush-register read |
| acc_valid | input | 1 | Datapath access present |
| acc_write | input | 1 | Access is a write |
| acc_alias | input | 2 | Address alias; 0 is cached and allocating |
| acc_sram | input | 1 | Access targets the cache-as-SRAM window |
| acc_hit | input | 1 | Tag match reported by the hit logic |
| acc_err | output | 1 | Return a bus error |
| acc_drop | output | 1 | Discard the write silently |
| line_inv | output | 1 | Invalidate the matching line |
| tag_clr_we | output | 1 | Tag-RAM clear strobe |
| tag_clr_idx | output | $clog2(NUM_LINES) | Tag-RAM index being cleared |
| cache_en | output | 1 | Cache enable level |
| cache_pd | output | 1 | Cache power-down level |
| lookup_en | output | 1 | Tag lookups may be used |
| flush_ready | output | 1 | No flush running |

## Verification
Access responses, register read data and the stall are combinational, so they are due in the cycle the request is presented. Control bits, flush start and each sequencer step take effect one clock edge after the write or the previous step. `flush_ready` therefore rises NUM_LINES edges after the start. The bench changes inputs just after each rising edge and advances its behavioural model on that edge. It compares every output against the model at the falling edge, which lets both the same-cycle and next-edge results settle before they are sampled.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_FLUSH = 2'd1,
        SEL_STAT  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    localparam int BIT_ENABLE = 0;
    localparam int BIT_BADWR  = 1;
    localparam int BIT_PWRDN  = 3;

    localparam logic [1:0] ALIAS_ALLOC = 2'd0;

    typedef struct packed {
        logic pwrdn;
        logic badwr;
        logic enable;
    } ctl_t;

    typedef struct packed {
        logic err;
        logic drop;
        logic inv;
    } resp_t;

    function automatic logic [31:0] ctl_to_word(ctl_t c);
        logic [31:0] w;
        w = '0;
        w[BIT_ENABLE] = c.enable;
        w[BIT_BADWR]  = c.badwr;
        w[BIT_PWRDN]  = c.pwrdn;
        return w;
    endfunction

    function automatic ctl_t word_to_ctl(logic [31:0] w);
        ctl_t c;
        c.pwrdn  = w[BIT_PWRDN];
        c.badwr  = w[BIT_BADWR];
        c.enable = w[BIT_ENABLE] & ~w[BIT_PWRDN];
        return c;
    endfunction

endpackage

// File: rtl/fcc_regs.sv
module fcc_regs
    import fcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_ctl,
    input  logic [31:0] wdata,
    output ctl_t        ctl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr_ctl) begin
            ctl <= word_to_ctl(wdata);
        end
    end

endmodule

// File: rtl/fcc_flush_seq.sv
module fcc_flush_seq #(
    parameter int NUM_LINES = 64,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             clr_we,
    output logic [IDX_W-1:0] clr_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b1;
            clr_idx <= '0;
        end else if (busy) begin
            if (clr_idx == LAST_IDX) begin
                busy    <= 1'b0;
                clr_idx <= '0;
            end else begin
                clr_idx <= clr_idx + 1'b1;
            end
        end else if (start) begin
            busy    <= 1'b1;
            clr_idx <= '0;
        end
    end

    assign clr_we = busy;

endmodule

// File: rtl/fcc_access_resp.sv
module fcc_access_resp
    import fcc_pkg::*;
(
    input  ctl_t       ctl,
    input  logic       seq_busy,
    input  logic       valid,
    input  logic       write,
    input  logic [1:0] alias_sel,
    input  logic       sram,
    input  logic       hit,
    output logic       lookup,
    output resp_t      resp
);

    logic alloc_alias;

    always_comb begin
        lookup      = ctl.enable & ~seq_busy;
        alloc_alias = (alias_sel == ALIAS_ALLOC);
        resp        = '0;
        if (valid) begin
            if (sram) begin
                resp.err = ctl.enable | ctl.pwrdn;
            end else if (write) begin
                if (alloc_alias) begin
                    resp.inv = hit & lookup;
                end else begin
                    resp.err  = ctl.badwr;
                    resp.drop = ~ctl.badwr;
                end
            end
        end
    end

endmodule

// File: rtl/flash_cache_ctl.sv
module flash_cache_ctl
    import fcc_pkg::*;
#(
    parameter int NUM_LINES = 64,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_valid,
    input  logic             reg_write,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             reg_stall,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [1:0]       acc_alias,
    input  logic             acc_sram,
    input  logic             acc_hit,
    output logic             acc_err,
    output logic             acc_drop,
    output logic             line_inv,
    output logic             tag_clr_we,
    output logic [IDX_W-1:0] tag_clr_idx,
    output logic             cache_en,
    output logic             cache_pd,
    output logic             lookup_en,
    output logic             flush_ready
);

    reg_sel_e sel;
    ctl_t     ctl;
    resp_t    resp;
    logic     seq_busy;
    logic     wr_ctl;
    logic     flush_req;

    assign sel       = reg_sel_e'(reg_addr);
    assign wr_ctl    = reg_valid & reg_write & (sel == SEL_CTRL);
    assign flush_req = reg_valid & reg_write & (sel == SEL_FLUSH) & reg_wdata[0];

    fcc_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_ctl (wr_ctl),
        .wdata  (reg_wdata),
        .ctl    (ctl)
    );

    fcc_flush_seq #(.NUM_LINES(NUM_LINES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (flush_req),
        .busy    (seq_busy),
        .clr_we  (tag_clr_we),
        .clr_idx (tag_clr_idx)
    );

    fcc_access_resp u_resp (
        .ctl       (ctl),
        .seq_busy  (seq_busy),
        .valid     (acc_valid),
        .write     (acc_write),
        .alias_sel (acc_alias),
        .sram      (acc_sram),
        .hit       (acc_hit),
        .lookup    (lookup_en),
        .resp      (resp)
    );

    always_comb begin
        unique case (sel)
            SEL_CTRL: reg_rdata = ctl_to_word(ctl);
            SEL_STAT: reg_rdata = {31'd0, ~seq_busy};
            default:  reg_rdata = '0;
        endcase
    end

    assign reg_stall   = reg_valid & ~reg_write & (sel == SEL_FLUSH) & seq_busy;
    assign acc_err     = resp.err;
    assign acc_drop    = resp.drop;
    assign line_inv    = resp.inv;
    assign cache_en    = ctl.enable;
    assign cache_pd    = ctl.pwrdn;
    assign flush_ready = ~seq_busy;

endmodule

// File: rtl/flash_cache_ctl_chk.sv
module flash_cache_ctl_chk #(
    parameter int NUM_LINES = 64,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_stall,
    input logic             acc_valid,
    input logic             acc_sram,
    input logic             acc_err,
    input logic             acc_drop,
    input logic             line_inv,
    input logic             tag_clr_we,
    input logic [IDX_W-1:0] tag_clr_idx,
    input logic             cache_en,
    input logic             cache_pd,
    input logic             lookup_en,
    input logic             flush_ready
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LINES - 1);

    // R3
    pd_excludes_en_chk: assert property (@(posedge clk) disable iff (rst)
        !(cache_en && cache_pd));

    // R4
    walk_steps_chk: assert property (@(posedge clk) disable iff (rst)
        (tag_clr_we && tag_clr_idx != LAST) |=> (tag_clr_we && tag_clr_idx == $past(tag_clr_idx) + 1'b1));

    // R5
    ready_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flush_ready) |-> ($past(tag_clr_we) && $past(tag_clr_idx) == LAST));

    // R5
    ready_vs_walk_chk: assert property (@(posedge clk) disable iff (rst)
        flush_ready |-> !tag_clr_we);

    // R6
    stall_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        reg_stall |-> !flush_ready);

    // R8
    lookup_gate_chk: assert property (@(posedge clk) disable iff (rst)
        lookup_en |-> (flush_ready && cache_en));

    // R11
    sram_err_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_sram && (cache_en || cache_pd)) |-> acc_err);

    // R9
    resp_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({acc_err, acc_drop, line_inv}) <= 1);

endmodule

bind flash_cache_ctl flash_cache_ctl_chk #(.NUM_LINES(NUM_LINES)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_stall   (reg_stall),
    .acc_valid   (acc_valid),
    .acc_sram    (acc_sram),
    .acc_err     (acc_err),
    .acc_drop    (acc_drop),
    .line_inv    (line_inv),
    .tag_clr_we  (tag_clr_we),
    .tag_clr_idx (tag_clr_idx),
    .cache_en    (cache_en),
    .cache_pd    (cache_pd),
    .lookup_en   (lookup_en),
    .flush_ready (flush_ready)
);

// File: tb/test_flash_cache_ctl.sv
module test_flash_cache_ctl;

    localparam int NL = 64;
    localparam int IW = $clog2(NL);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_valid = 0, reg_write = 0;
    logic [1:0]    reg_addr = 0;
    logic [31:0]   reg_wdata = 0;
    logic [31:0]   reg_rdata;
    logic          reg_stall;
    logic          acc_valid = 0, acc_write = 0, acc_sram = 0, acc_hit = 0;
    logic [1:0]    acc_alias = 0;
    logic          acc_err, acc_drop, line_inv, tag_clr_we;
    logic [IW-1:0] tag_clr_idx;
    logic          cache_en, cache_pd, lookup_en, flush_ready;

    int n_chk = 0;
    int n_err = 0;

    flash_cache_ctl #(.NUM_LINES(NL)) i_flash_cache_ctl (
        .clk(clk), .rst(rst),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_stall(reg_stall),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_alias(acc_alias),
        .acc_sram(acc_sram), .acc_hit(acc_hit),
        .acc_err(acc_err), .acc_drop(acc_drop), .line_inv(line_inv),
        .tag_clr_we(tag_clr_we), .tag_clr_idx(tag_clr_idx),
        .cache_en(cache_en), .cache_pd(cache_pd),
        .lookup_en(lookup_en), .flush_ready(flush_ready)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    bit m_armed = 0;
    bit m_busy, m_en, m_bad, m_pd;
    int m_idx;

    always @(posedge clk) begin
        m_armed <= 1'b1;
        if (rst) begin
            m_busy = 1; m_idx = 0; m_en = 0; m_bad = 0; m_pd = 0;
        end else begin
            if (m_busy) begin
                if (m_idx == NL - 1) begin m_busy = 0; m_idx = 0; end
                else m_idx = m_idx + 1;
            end else if (reg_valid && reg_write && reg_addr == 2'd1 && reg_wdata[0]) begin
                m_busy = 1; m_idx = 0;
            end
            if (reg_valid && reg_write && reg_addr == 2'd0) begin
                m_pd  = reg_wdata[3];
                m_bad = reg_wdata[1];
                m_en  = reg_wdata[0] && !reg_wdata[3];
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_armed) begin
            bit lk, e_err, e_drop, e_inv, e_stall;
            logic [31:0] e_rd;
            lk = m_en && !m_busy;
            e_err = 0; e_drop = 0; e_inv = 0;
            if (acc_valid) begin
                if (acc_sram) e_err = m_en || m_pd;
                else if (acc_write && acc_alias != 0) begin e_err = m_bad; e_drop = !m_bad; end
                else if (acc_write) e_inv = acc_hit && lk;
            end
            e_stall = reg_valid && !reg_write && reg_addr == 2'd1 && m_busy;
            case (reg_addr)
                2'd0: e_rd = {28'd0, m_pd, 1'b0, m_bad, m_en};
                2'd2: e_rd = {31'd0, !m_busy};
                default: e_rd = 32'd0;
            endcase
            chk("R1/R4 tag_clr_we", tag_clr_we, m_busy);
            if (m_busy) chk("R4 tag_clr_idx", tag_clr_idx, m_idx);
            chk("R5 flush_ready", flush_ready, !m_busy);
            chk("R3 cache_en", cache_en, m_en);
            chk("R3 cache_pd", cache_pd, m_pd);
            chk("R8 lookup_en", lookup_en, lk);
            chk("R6 reg_stall", reg_stall, e_stall);
            if (reg_valid && !reg_write && !e_stall) chk("R2 reg_rdata", reg_rdata, e_rd);
            chk("R9/R11 acc_err", acc_err, e_err);
            chk("R9 acc_drop", acc_drop, e_drop);
            chk("R10 line_inv", line_inv, e_inv);
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic reg_wr(logic [1:0] a, logic [31:0] d);
        reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_valid = 0; reg_write = 0; reg_wdata = 0;
    endtask

    task automatic reg_rd(logic [1:0] a, logic [31:0] exp, string tag);
        reg_valid = 1; reg_write = 0; reg_addr = a;
        forever begin
            @(negedge clk);
            if (!reg_stall) break;
        end
        chk(tag, reg_rdata, exp);
        @(posedge clk); #1;
        reg_valid = 0;
    endtask

    task automatic acc(bit w, logic [1:0] al, bit sr, bit h, bit exp_err, string tag);
        acc_valid = 1; acc_write = w; acc_alias = al; acc_sram = sr; acc_hit = h;
        @(negedge clk);
        chk(tag, acc_err, exp_err);
        @(posedge clk); #1;
        acc_valid = 0; acc_write = 0; acc_sram = 0; acc_hit = 0; acc_alias = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        rst = 1;
        idle(3);
        rst = 0;
        // R1 / R6: automatic flush; read of flush register stalls through it
        reg_rd(2'd1, 32'd0, "R6 flush read after stall");
        reg_rd(2'd2, 32'd1, "R5 status ready");
        reg_rd(2'd0, 32'd0, "R1 control reset value");
        // R2: enable + bad-write
        reg_wr(2'd0, 32'h3);
        reg_rd(2'd0, 32'h3, "R2 control readback");
        acc(1, 2'd1, 0, 0, 1, "R9 bad alias write errors");
        acc(1, 2'd2, 0, 0, 1, "R9 bad alias 2 write errors");
        acc(0, 2'd1, 0, 0, 0, "R9 alias read no error");
        acc(0, 2'd0, 1, 0, 1, "R11 sram read while enabled");
        acc(1, 2'd0, 0, 1, 0, "R10 alloc write hit invalidates");
        // bad-write off
        reg_wr(2'd0, 32'h1);
        acc(1, 2'd3, 0, 0, 0, "R9 dropped write no error");
        acc(1, 2'd0, 0, 1, 0, "R10 invalidate with badwr 0");
        // R3: power-down forces enable low
        reg_wr(2'd0, 32'h9);
        reg_rd(2'd0, 32'h8, "R3 pd clears enable");
        acc(1, 2'd0, 1, 0, 1, "R11 sram write while powered down");
        reg_wr(2'd0, 32'h0);
        acc(1, 2'd0, 1, 0, 0, "R11 sram ok when off");
        // R4 / R7 / R8: software flush, repeated request ignored
        reg_wr(2'd0, 32'h1);
        reg_wr(2'd1, 32'h1);
        idle(5);
        reg_wr(2'd1, 32'h1);
        acc(1, 2'd0, 0, 1, 0, "R8 no invalidate during flush");
        reg_rd(2'd2, 32'd0, "R5 status busy");
        reg_rd(2'd1, 32'd0, "R6 flush read stalls then 0");
        reg_rd(2'd2, 32'd1, "R5 status ready again");
        // R4: bit 0 clear starts nothing
        reg_wr(2'd1, 32'h2);
        idle(3);
        reg_rd(2'd2, 32'd1, "R4 no flush from bit0 clear");
        acc(1, 2'd0, 0, 1, 0, "R10 invalidate after flush");
        idle(4);
        finish_run();
    end

endmodule